// File: doc/BRIEF.md
# Byte-Stream Memory Command Monitor

This block lets a host that can only exchange single bytes read and write a word-addressed on-chip storage array. It sits between a byte receiver and a byte transmitter, each with a valid/ready handshake. It decodes a small command language from the incoming bytes and runs one storage access for each command. It then sends back a fixed-length reply that ends in a status byte.

A command opens with an operation byte: 0x00 selects a read and 0x01 selects a write. Four bytes of a 32-bit word address follow, lowest byte first. A write then carries four data bytes, also lowest byte first. A read answers with the four bytes of the stored word, lowest byte first. Every command finishes with one status byte, and the block then waits for the next operation byte. The mapped window, a read-only sub-window and the inactivity limit are parameters. The storage sees the command address minus the window base.

Top module: `memCmdMonitor`

## Requirements
- R1: An operation byte other than 0x00 (read) or 0x01 (write) consumes no further input and produces the single status byte 0x01 (protocol error).
- R2: The four address bytes are taken lowest byte first into a 32-bit address; the storage address is that address minus MAP_BASE, truncated to MEM_AW bits.
- R3: A write takes four data bytes lowest byte first. It drives a one-cycle memWe pulse in the cycle after the last data byte is accepted, then sends status 0x00.
- R4: A read of a mapped address returns the stored word as four bytes, lowest byte first, followed by status 0x00; the storage read has one cycle of latency.
- R5: An address outside [MAP_BASE, MAP_BASE+MAP_WORDS) is unmapped: a read returns four 0x00 bytes then status 0x02, and a write issues no storage write and sends status 0x02.
- R6: A write to an address in [RO_BASE, RO_BASE+RO_WORDS) issues no storage write and sends status 0x03; reads in that window behave as in R4.
- R7: If IDLE_LIMIT consecutive cycles pass without an accepted byte while the address or data bytes are expected, the command is dropped with no storage write, and status 0x01 is offered in the cycle after the IDLE_LIMIT-th idle cycle.
- R8: inReady is low whenever outValid is high, and an offered output byte stays valid and unchanged until outReady takes it.
- R9: After reset inReady is 1 and outValid and memWe are 0; after each status byte is taken the block accepts a new operation byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Incoming command byte |
| inValid | input | 1 | Incoming byte is present |
| inReady | output | 1 | Block accepts the incoming byte |
| outData | output | 8 | Reply byte |
| outValid | output | 1 | Reply byte is present |
| outReady | input | 1 | Transmitter takes the reply byte |
| memAddr | output | MEM_AW | Storage word address |
| memWdata | output | 32 | Storage write word |
| memWe | output | 1 | Storage write strobe |
| memRdata | input | 32 | Storage read word, one cycle after memAddr |

## Verification
The hardest case to reach from the ports is the inactivity abort. It needs a command that stops partway through and then stays silent for exactly the right number of cycles, with the status checked on the exact cycle it first appears. The stimulus stops after two address bytes, counts clock edges from the last accepted byte, and checks that outValid is still low one cycle before the limit and high at the limit. A second abort comes after two data bytes, and a read-back then shows that the storage kept its old word. The reply path is also run with a pseudo-random outReady, so that held bytes and blocked input overlap with every reply byte.

// File: rtl/memCmdMonitorPkg.sv
package memCmdMonitorPkg;

  localparam int WORD_W = 32;

  localparam logic [7:0] OP_READ       = 8'h00;
  localparam logic [7:0] OP_WRITE      = 8'h01;
  localparam logic [7:0] STAT_OK       = 8'h00;
  localparam logic [7:0] STAT_PROTO    = 8'h01;
  localparam logic [7:0] STAT_UNMAPPED = 8'h02;
  localparam logic [7:0] STAT_READONLY = 8'h03;

  typedef enum logic [2:0] {
    ST_OPCODE, ST_ADDR, ST_DATA, ST_WRITE,
    ST_RDREQ, ST_RDCAP, ST_SEND, ST_STATUS
  } monState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic       addrShift;
    logic       dataShift;
    logic       rdLoad;
    logic       outShift;
    logic       statLoad;
    logic [7:0] statCode;
    logic       idleRun;
    logic       sendStatus;
  } monStrobe_t;

endpackage

// File: rtl/memCmdMonitorPath.sv
module memCmdMonitorPath
  import memCmdMonitorPkg::*;
#(
  parameter int          MEM_AW     = 6,
  parameter int          IDLE_LIMIT = 40,
  parameter logic [31:0] MAP_BASE   = 32'h0000_0100,
  parameter logic [31:0] MAP_WORDS  = 32'd64,
  parameter logic [31:0] RO_BASE    = 32'h0000_0100,
  parameter logic [31:0] RO_WORDS   = 32'd8
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobe_t        strb,
  input  logic [7:0]        inData,
  input  logic [WORD_W-1:0] memRdata,
  output logic [7:0]        outData,
  output logic [MEM_AW-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              isMapped,
  output logic              isReadOnly,
  output logic              idleExpired
);

  localparam int          IDLE_W  = $clog2(IDLE_LIMIT + 1);
  localparam logic [32:0] MAP_END = {1'b0, MAP_BASE} + {1'b0, MAP_WORDS};
  localparam logic [32:0] RO_END  = {1'b0, RO_BASE} + {1'b0, RO_WORDS};

  logic [31:0]       cmdAddr;
  logic [WORD_W-1:0] dataWord;
  logic [7:0]        statusReg;
  logic [IDLE_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdAddr   <= '0;
      dataWord  <= '0;
      statusReg <= '0;
      idleCnt   <= '0;
    end else begin
      if (strb.addrShift) cmdAddr <= {inData, cmdAddr[31:8]};
      if (strb.dataShift)     dataWord <= {inData, dataWord[WORD_W-1:8]};
      else if (strb.rdLoad)   dataWord <= isMapped ? memRdata : '0;
      else if (strb.outShift) dataWord <= {8'h00, dataWord[WORD_W-1:8]};
      if (strb.statLoad) statusReg <= strb.statCode;
      if (!strb.idleRun || strb.addrShift || strb.dataShift) idleCnt <= '0;
      else                                                   idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    isMapped    = ({1'b0, cmdAddr} >= {1'b0, MAP_BASE}) && ({1'b0, cmdAddr} < MAP_END);
    isReadOnly  = ({1'b0, cmdAddr} >= {1'b0, RO_BASE})  && ({1'b0, cmdAddr} < RO_END);
    idleExpired = (idleCnt == IDLE_W'(IDLE_LIMIT - 1));
    memAddr     = MEM_AW'(cmdAddr - MAP_BASE);
    memWdata    = dataWord;
    outData     = strb.sendStatus ? statusReg : dataWord[7:0];
  end

endmodule

// File: rtl/memCmdMonitorCtrl.sv
module memCmdMonitorCtrl
  import memCmdMonitorPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       isMapped,
  input  logic       isReadOnly,
  input  logic       idleExpired,
  output logic       inReady,
  output logic       outValid,
  output logic       memWe,
  output monStrobe_t strb
);

  monState_t state, stateNxt;
  logic [1:0] byteCnt, byteCntNxt;
  logic       isWrite, isWriteNxt;
  logic       inTake, outTake;

  always_comb begin
    inReady    = (state == ST_OPCODE) || (state == ST_ADDR) || (state == ST_DATA);
    outValid   = (state == ST_SEND) || (state == ST_STATUS);
    inTake     = inReady && inValid;
    outTake    = outValid && outReady;
    memWe      = 1'b0;
    strb       = '0;
    stateNxt   = state;
    byteCntNxt = byteCnt;
    isWriteNxt = isWrite;
    case (state)
      ST_OPCODE: if (inTake) begin
        if (inData == OP_READ || inData == OP_WRITE) begin
          isWriteNxt = (inData == OP_WRITE);
          byteCntNxt = 2'd0;
          stateNxt   = ST_ADDR;
        end else begin
          strb.statLoad = 1'b1;
          strb.statCode = STAT_PROTO;
          stateNxt      = ST_STATUS;
        end
      end
      ST_ADDR, ST_DATA: begin
        strb.idleRun = 1'b1;
        if (inTake) begin
          strb.addrShift = (state == ST_ADDR);
          strb.dataShift = (state == ST_DATA);
          byteCntNxt     = byteCnt + 2'd1;
          if (byteCnt == 2'd3) begin
            if (state == ST_DATA) stateNxt = ST_WRITE;
            else                  stateNxt = isWrite ? ST_DATA : ST_RDREQ;
          end
        end else if (idleExpired) begin
          strb.statLoad = 1'b1;
          strb.statCode = STAT_PROTO;
          stateNxt      = ST_STATUS;
        end
      end
      ST_WRITE: begin
        strb.statLoad = 1'b1;
        if (!isMapped)       strb.statCode = STAT_UNMAPPED;
        else if (isReadOnly) strb.statCode = STAT_READONLY;
        else begin
          strb.statCode = STAT_OK;
          memWe         = 1'b1;
        end
        stateNxt = ST_STATUS;
      end
      ST_RDREQ: stateNxt = ST_RDCAP;
      ST_RDCAP: begin
        strb.rdLoad   = 1'b1;
        strb.statLoad = 1'b1;
        strb.statCode = isMapped ? STAT_OK : STAT_UNMAPPED;
        byteCntNxt    = 2'd0;
        stateNxt      = ST_SEND;
      end
      ST_SEND: if (outTake) begin
        strb.outShift = 1'b1;
        byteCntNxt    = byteCnt + 2'd1;
        if (byteCnt == 2'd3) stateNxt = ST_STATUS;
      end
      ST_STATUS: begin
        strb.sendStatus = 1'b1;
        if (outTake) stateNxt = ST_OPCODE;
      end
      default: stateNxt = ST_OPCODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OPCODE;
      byteCnt <= 2'd0;
      isWrite <= 1'b0;
    end else begin
      state   <= stateNxt;
      byteCnt <= byteCntNxt;
      isWrite <= isWriteNxt;
    end
  end

endmodule

// File: rtl/memCmdMonitor.sv
module memCmdMonitor
  import memCmdMonitorPkg::*;
#(
  parameter int          MEM_AW     = 6,
  parameter int          IDLE_LIMIT = 40,
  parameter logic [31:0] MAP_BASE   = 32'h0000_0100,
  parameter logic [31:0] MAP_WORDS  = 32'd64,
  parameter logic [31:0] RO_BASE    = 32'h0000_0100,
  parameter logic [31:0] RO_WORDS   = 32'd8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [7:0]        outData,
  output logic              outValid,
  input  logic              outReady,
  output logic [MEM_AW-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              memWe,
  input  logic [31:0]       memRdata
);

  monStrobe_t strb;
  logic       isMapped, isReadOnly, idleExpired;

  memCmdMonitorCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .outReady(outReady), .isMapped(isMapped), .isReadOnly(isReadOnly),
    .idleExpired(idleExpired), .inReady(inReady), .outValid(outValid),
    .memWe(memWe), .strb(strb)
  );

  memCmdMonitorPath #(
    .MEM_AW(MEM_AW), .IDLE_LIMIT(IDLE_LIMIT), .MAP_BASE(MAP_BASE),
    .MAP_WORDS(MAP_WORDS), .RO_BASE(RO_BASE), .RO_WORDS(RO_WORDS)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .memRdata(memRdata), .outData(outData), .memAddr(memAddr),
    .memWdata(memWdata), .isMapped(isMapped), .isReadOnly(isReadOnly),
    .idleExpired(idleExpired)
  );

endmodule

// File: rtl/memCmdMonitorChecker.sv
module memCmdMonitorChecker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       memWe
);

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R8

  AST_WRITE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(inValid && inReady)); // R3

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R3

  AST_WRITE_THEN_OK: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (outValid && outData == 8'h00)); // R3

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (inReady && !outValid && !memWe)); // R9

endmodule

bind memCmdMonitor memCmdMonitorChecker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outData(outData), .outValid(outValid), .outReady(outReady), .memWe(memWe)
);

// File: tb/memCmdMonitor_bench.sv
module memCmdMonitor_bench;

  localparam int          MEM_AW     = 6;
  localparam int          DEPTH      = 1 << MEM_AW;
  localparam int          IDLE_LIMIT = 40;
  localparam logic [31:0] MAP_BASE   = 32'h0000_0100;
  localparam logic [31:0] MAP_WORDS  = 32'd64;
  localparam logic [31:0] RO_BASE    = 32'h0000_0100;
  localparam logic [31:0] RO_WORDS   = 32'd8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        inData = 8'h00;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [7:0]        outData;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [MEM_AW-1:0] memAddr;
  logic [31:0]       memWdata;
  logic              memWe;
  logic [31:0]       memRdata;

  logic [31:0] memModel [DEPTH];
  logic [31:0] refMem [DEPTH];
  logic [7:0]        expQ[$];
  string             tagQ[$];
  logic [MEM_AW-1:0] wrAddrQ[$];
  logic [31:0]       wrDataQ[$];
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic stall = 1'b0;
  logic [7:0] lfsr = 8'h01;

  always #2 clk = ~clk;

  memCmdMonitor #(
    .MEM_AW(MEM_AW), .IDLE_LIMIT(IDLE_LIMIT), .MAP_BASE(MAP_BASE),
    .MAP_WORDS(MAP_WORDS), .RO_BASE(RO_BASE), .RO_WORDS(RO_WORDS)
  ) u_memCmdMonitor (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata)
  );

  function automatic logic [31:0] initWord(int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0103_0507);
  endfunction

  // storage with one cycle read latency
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memModel[i] <= initWord(i);
      memRdata <= '0;
    end else begin
      if (memWe) memModel[memAddr] <= memWdata;
      memRdata <= memModel[memAddr];
    end
  end

  task automatic fail(string msg);
    miscompares++;
    $display("FAIL %s", msg);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // reference comparison on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      outReady = stall ? lfsr[0] : 1'b1;
      vectors++;
      if (inReady && outValid)
        fail($sformatf("R8: inReady actual %0b expected 0 while outValid", inReady));
      if (outValid && outReady) begin
        vectors++;
        if (expQ.size() == 0) fail($sformatf("R8: reply byte actual %02h expected none", outData));
        else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (outData !== e) fail($sformatf("%s: reply byte actual %02h expected %02h", t, outData, e));
        end
      end
      if (memWe) begin
        vectors++;
        if (wrAddrQ.size() == 0)
          fail($sformatf("R5/R6/R7: write actual addr %0h expected no write", memAddr));
        else begin
          logic [MEM_AW-1:0] ea;
          logic [31:0] ed;
          ea = wrAddrQ.pop_front();
          ed = wrDataQ.pop_front();
          if (memAddr !== ea || memWdata !== ed)
            fail($sformatf("R3: write actual %0h/%08h expected %0h/%08h", memAddr, memWdata, ea, ed));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL R9: watchdog actual %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic putByte(input logic [7:0] b);
    bit took;
    @(negedge clk);
    inData  = b;
    inValid = 1'b1;
    took = 1'b0;
    while (!took) begin
      took = inReady;
      @(posedge clk);
      if (!took) @(negedge clk);
    end
  endtask

  task automatic releaseIn();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expect8(input logic [7:0] b, input string t);
    expQ.push_back(b);
    tagQ.push_back(t);
  endtask

  task automatic waitDone();
    while (expQ.size() != 0 || wrAddrQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic runCmd(input logic [7:0] op, input logic [31:0] addr,
                        input logic [31:0] data, input string t);
    bit mapped, ro;
    logic [MEM_AW-1:0] idx;
    mapped = (addr >= MAP_BASE) && ({1'b0, addr} < {1'b0, MAP_BASE} + {1'b0, MAP_WORDS});
    ro     = (addr >= RO_BASE) && ({1'b0, addr} < {1'b0, RO_BASE} + {1'b0, RO_WORDS});
    idx    = MEM_AW'(addr - MAP_BASE);
    if (op > 8'h01) begin
      expect8(8'h01, t);
      putByte(op);
      releaseIn();
      waitDone();
      return;
    end
    if (op == 8'h00) begin
      for (int k = 0; k < 4; k++) expect8(mapped ? 8'(refMem[idx] >> (8 * k)) : 8'h00, t);
      expect8(mapped ? 8'h00 : 8'h02, t);
    end else begin
      if (!mapped)  expect8(8'h02, t);
      else if (ro)  expect8(8'h03, t);
      else begin
        expect8(8'h00, t);
        wrAddrQ.push_back(idx);
        wrDataQ.push_back(data);
        refMem[idx] = data;
      end
    end
    putByte(op);
    for (int k = 0; k < 4; k++) putByte(8'(addr >> (8 * k)));
    if (op == 8'h01) for (int k = 0; k < 4; k++) putByte(8'(data >> (8 * k)));
    releaseIn();
    waitDone();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = initWord(i);
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    vectors += 3; // R9 reset state
    if (inReady !== 1'b1) fail($sformatf("R9: inReady actual %0b expected 1", inReady));
    if (outValid !== 1'b0) fail($sformatf("R9: outValid actual %0b expected 0", outValid));
    if (memWe !== 1'b0) fail($sformatf("R9: memWe actual %0b expected 0", memWe));

    runCmd(8'h01, 32'h0000_0125, 32'hDEAD_BEEF, "R3");
    runCmd(8'h00, 32'h0000_0125, 32'h0, "R4");
    runCmd(8'h00, 32'h0000_0111, 32'h0, "R4");
    runCmd(8'h01, 32'h0000_013A, 32'h1234_5678, "R2");
    runCmd(8'h00, 32'h0000_013A, 32'h0, "R2");
    runCmd(8'h00, 32'h0100_013A, 32'h0, "R2");
    runCmd(8'h00, 32'h0000_013F, 32'h0, "R5");
    runCmd(8'h00, 32'h0000_0140, 32'h0, "R5");
    runCmd(8'h00, 32'h0000_00FF, 32'h0, "R5");
    runCmd(8'h01, 32'h0000_0000, 32'hAAAA_5555, "R5");
    runCmd(8'h01, 32'h0000_0102, 32'h0BAD_0BAD, "R6");
    runCmd(8'h00, 32'h0000_0102, 32'h0, "R6");
    runCmd(8'h01, 32'h0000_0107, 32'h0BAD_F00D, "R6");
    runCmd(8'h01, 32'h0000_0108, 32'hCAFE_F00D, "R6");
    runCmd(8'h00, 32'h0000_0108, 32'h0, "R6");
    runCmd(8'h07, 32'h0, 32'h0, "R1");
    runCmd(8'hFF, 32'h0, 32'h0, "R1");
    runCmd(8'h00, 32'h0000_0125, 32'h0, "R9");

    // R7: stall after two address bytes, check exact abort cycle
    expect8(8'h01, "R7");
    putByte(8'h00);
    putByte(8'h25);
    releaseIn();
    repeat (IDLE_LIMIT - 1) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (outValid !== 1'b0) fail($sformatf("R7: early outValid actual %0b expected 0", outValid));
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (outValid !== 1'b1) fail($sformatf("R7: outValid actual %0b expected 1", outValid));
    waitDone();

    // R7: abort in the data phase leaves storage unchanged
    expect8(8'h01, "R7");
    putByte(8'h01);
    putByte(8'h30); putByte(8'h01); putByte(8'h00); putByte(8'h00);
    putByte(8'h99); putByte(8'h88);
    releaseIn();
    waitDone();
    runCmd(8'h00, 32'h0000_0130, 32'h0, "R7");

    // R8: back-pressure on the reply path
    stall = 1'b1;
    runCmd(8'h01, 32'h0000_0120, 32'h0102_0304, "R8");
    runCmd(8'h00, 32'h0000_0120, 32'h0, "R8");
    runCmd(8'h00, 32'h0000_0200, 32'h0, "R8");
    runCmd(8'h05, 32'h0, 32'h0, "R8");
    for (int j = 0; j < 6; j++)
      runCmd(8'h00, MAP_BASE + 32'(j * 9), 32'h0, "R8");
    stall = 1'b0;

    report();
  end

endmodule